// File: doc/BRIEF.md
# Shortened BCH (350,300) Parallel Encoder

This block turns a stream of 300 information bits into a 350-bit systematic codeword of a binary, five-error-correcting BCH code whose symbols and roots live in GF(2^10). Information arrives as 10-bit words, one per clock when offered. Each accepted word is copied to the output on the next clock. At the same time a 50-bit remainder register is advanced by ten bit-steps in one cycle. Once the thirtieth word has been taken, the remainder is drained as five 10-bit parity words on back-to-back cycles. During that drain the block refuses input.

A word sent with the start flag opens a codeword and clears the remainder. This is also true when a previous codeword is still partly collected: that partial codeword is abandoned. The source may pause at any point inside a codeword, or between codewords, without changing the result.

Top module: `bch350_enc`

## Requirements
- R1: Every accepted information word leaves on `out_data` unchanged, in acceptance order, with `out_parity` low. Bit 9 of each word is its earliest bit and has the highest polynomial degree. Bit 9 of the first word is the coefficient of x^299.
- R2: A word accepted at a clock edge (`in_valid` and `in_ready` high) shows on `out_data` with `out_valid` high right after the next clock edge, which is one cycle of latency.
- R3: The 50 parity bits equal the remainder of x^50·m(x) divided by g(x). The field polynomial is x^10+x^3+1. g(x) is the least degree binary polynomial with roots α, α^3, α^5, α^7 and α^9. The whole 350-bit codeword is divisible by g(x).
- R4: After the thirtieth information word, five parity words follow on consecutive cycles with `out_parity` high. The remainder coefficient of x^49 comes first, as bit 9 of the first parity word. `out_last` is high on the fifth parity word only.
- R5: `in_ready` is low for the five cycles that follow the acceptance of the thirtieth word. Anything offered in those cycles, start flag included, produces no output and does not alter the codeword.
- R6: Cycles with `in_valid` low inside a codeword produce no output and leave the parity unchanged.
- R7: A word with `in_start` high clears the remainder and counts as word 1 of a new codeword. A partly collected codeword is abandoned by this.
- R8: While no codeword is open, words offered without `in_start` are ignored.
- R9: After reset `out_valid` is low, `in_ready` is high and no codeword is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Information word offered |
| in_start | input | 1 | Offered word opens a new codeword |
| in_data | input | 10 | Information word, bit 9 earliest |
| in_ready | output | 1 | Block accepts a word this cycle |
| out_valid | output | 1 | Output word valid |
| out_data | output | 10 | Codeword word, information then parity |
| out_parity | output | 1 | Output word is a parity word |
| out_last | output | 1 | Final parity word of the codeword |

## Verification
The bench aims at the remainder in its extreme cases: all-zero and all-one information, a lone x^299 bit and a lone x^50 bit. An update chain with a swapped tap or a reversed bit order gives wrong parity or a codeword that g(x) does not divide. During the parity drain it offers words, some with the start flag. A block that lets `in_ready` rise early would corrupt the remainder or cut the parity short. Random pauses inside codewords expose a block that advances its count or remainder on idle cycles. An abandoned partial codeword, and stray words sent with no codeword open, expose a remainder that is not cleared at start and a block that opens a codeword without a start.

// File: rtl/bch_enc_pkg.sv
package bch_enc_pkg;
  localparam int SYM_W = 10;                    // field degree m
  localparam int T_CORR = 5;                    // correctable errors
  localparam int PAR_W = SYM_W * T_CORR;        // generator degree
  localparam logic [SYM_W:0] PRIM = 11'h409;    // x^10 + x^3 + 1

  // multiply two field elements, polynomial basis
  function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a,
                                               input logic [SYM_W-1:0] b);
    logic [SYM_W-1:0] p;
    p = '0;
    for (int i = SYM_W - 1; i >= 0; i--) begin
      p = {p[SYM_W-2:0], 1'b0} ^ (p[SYM_W-1] ? PRIM[SYM_W-1:0] : '0);
      if (b[i]) p = p ^ a;
    end
    return p;
  endfunction

  // generator = product of (x + beta) over every conjugate of the odd roots
  function automatic logic [PAR_W:0] gen_poly();
    logic [SYM_W-1:0] c [0:PAR_W];
    logic [SYM_W-1:0] beta;
    logic [PAR_W:0]   g;
    int deg;
    for (int k = 0; k <= PAR_W; k++) c[k] = '0;
    c[0] = SYM_W'(1);
    deg = 0;
    for (int e = 1; e < 2 * T_CORR; e += 2) begin
      beta = SYM_W'(1);
      for (int k = 0; k < e; k++) beta = gf_mul(beta, SYM_W'(2));
      for (int j = 0; j < SYM_W; j++) begin
        for (int k = deg + 1; k >= 1; k--) c[k] = c[k-1] ^ gf_mul(c[k], beta);
        c[0] = gf_mul(c[0], beta);
        deg = deg + 1;
        beta = gf_mul(beta, beta);
      end
    end
    for (int k = 0; k <= PAR_W; k++) g[k] = c[k][0];
    return g;
  endfunction
endpackage

// File: rtl/bch_rem_step.sv
// Advances the division remainder by DATA_W message bits in one cycle:
// an unrolled chain of single-bit LFSR stages, earliest bit first.
module bch_rem_step #(
  parameter int DATA_W = 10,
  parameter int PAR_W = 50,
  parameter logic [PAR_W-1:0] GTAP = '0
) (
  input  logic [PAR_W-1:0]  rem_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [PAR_W-1:0]  rem_o
);
  genvar s;
  generate
    for (s = 0; s < DATA_W; s++) begin : g_bit
      logic [PAR_W-1:0] prv;
      logic [PAR_W-1:0] nxt;
      logic fb;
      if (s == 0) begin : g_first
        assign prv = rem_i;
      end else begin : g_chain
        assign prv = g_bit[s-1].nxt;
      end
      assign fb  = data_i[DATA_W-1-s] ^ prv[PAR_W-1];
      assign nxt = {prv[PAR_W-2:0], 1'b0} ^ (fb ? GTAP : '0);
    end
  endgenerate

  assign rem_o = g_bit[DATA_W-1].nxt;
endmodule

// File: rtl/bch_enc_seq.sv
// Codeword sequencing: information word count, parity drain count, ready.
module bch_enc_seq #(
  parameter int INFO_WORDS = 30,
  parameter int PAR_WORDS = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_start,
  output logic in_ready,
  output logic take,
  output logic par_en,
  output logic par_last
);
  localparam int CNT_W  = $clog2(INFO_WORDS);
  localparam int PCNT_W = (PAR_WORDS > 1) ? $clog2(PAR_WORDS) : 1;

  logic              open_q;
  logic              par_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PCNT_W-1:0] pcnt_q;
  logic [CNT_W-1:0]  base_cnt;

  assign in_ready = !par_q;
  assign take     = in_valid && !par_q && (open_q || in_start);
  assign base_cnt = in_start ? '0 : cnt_q;
  assign par_en   = par_q;
  assign par_last = par_q && (pcnt_q == PCNT_W'(PAR_WORDS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      par_q  <= 1'b0;
      cnt_q  <= '0;
      pcnt_q <= '0;
    end else if (take) begin
      if (base_cnt == CNT_W'(INFO_WORDS - 1)) begin
        open_q <= 1'b0;
        par_q  <= 1'b1;
        cnt_q  <= '0;
        pcnt_q <= '0;
      end else begin
        open_q <= 1'b1;
        cnt_q  <= base_cnt + CNT_W'(1);
      end
    end else if (par_q) begin
      pcnt_q <= pcnt_q + PCNT_W'(1);
      if (par_last) par_q <= 1'b0;
    end
  end

  AST_NO_TAKE_IN_DRAIN: assert property (@(posedge clk) disable iff (rst)
    par_q && !par_last |=> par_q && !take); // R5
endmodule

// File: rtl/bch350_enc.sv
module bch350_enc #(
  parameter int DATA_W = bch_enc_pkg::SYM_W,
  parameter int INFO_WORDS = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_start,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_parity,
  output logic              out_last
);
  localparam int PAR_W = bch_enc_pkg::PAR_W;
  localparam int PAR_WORDS = PAR_W / DATA_W;
  localparam logic [PAR_W:0] GEN = bch_enc_pkg::gen_poly();

  logic             take, par_en, par_last;
  logic [PAR_W-1:0] rem_q, rem_base, rem_nxt;

  bch_enc_seq #(.INFO_WORDS(INFO_WORDS), .PAR_WORDS(PAR_WORDS)) u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
    .in_ready(in_ready), .take(take), .par_en(par_en), .par_last(par_last)
  );

  assign rem_base = in_start ? '0 : rem_q;

  bch_rem_step #(.DATA_W(DATA_W), .PAR_W(PAR_W), .GTAP(GEN[PAR_W-1:0])) u_step (
    .rem_i(rem_base), .data_i(in_data), .rem_o(rem_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q      <= '0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_parity <= 1'b0;
      out_last   <= 1'b0;
    end else begin
      out_valid <= take || par_en;
      if (take) begin
        rem_q      <= rem_nxt;
        out_data   <= in_data;
        out_parity <= 1'b0;
        out_last   <= 1'b0;
      end else if (par_en) begin
        rem_q      <= rem_q << DATA_W;
        out_data   <= rem_q[PAR_W-1 -: DATA_W];
        out_parity <= 1'b1;
        out_last   <= par_last;
      end else begin
        out_parity <= 1'b0;
        out_last   <= 1'b0;
      end
    end
  end

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_start |=> out_valid && !out_parity && out_data == $past(in_data)); // R2
  AST_PAR_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    out_parity && !out_last |=> out_valid && out_parity); // R4
  AST_LAST_IS_FIFTH: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_parity && $past(out_parity, 4)); // R4
  AST_READY_LOW_DRAIN: assert property (@(posedge clk) disable iff (rst)
    out_parity && !out_last |-> !in_ready); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    in_ready && !in_valid |=> !out_valid); // R6
endmodule

// File: tb/tb_bch350_enc.sv
`timescale 1ns/1ps
module tb_bch350_enc;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0, in_start = 1'b0;
  logic [9:0] in_data = '0;
  logic       in_ready, out_valid, out_parity, out_last;
  logic [9:0] out_data;

  always #2.5 clk = ~clk;

  bch350_enc dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_parity(out_parity), .out_last(out_last)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int exp_t [0:1022];
  int log_t [0:1023];
  logic [50:0] g_ref;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int fmul(input int a, input int b);
    if (a == 0 || b == 0) return 0;
    return exp_t[(log_t[a] + log_t[b]) % 1023];
  endfunction

  task automatic build_gen();
    int v;
    int c [0:50];
    int deg;
    v = 1;
    for (int i = 0; i < 1023; i++) begin
      exp_t[i] = v;
      log_t[v] = i;
      v = v << 1;
      if ((v & 1024) != 0) v = v ^ 32'h409;
    end
    for (int k = 0; k <= 50; k++) c[k] = 0;
    c[0] = 1;
    deg = 0;
    for (int e = 1; e <= 9; e += 2)
      for (int j = 0; j < 10; j++) begin
        int b;
        b = exp_t[(e * (1 << j)) % 1023];
        for (int k = deg + 1; k >= 1; k--) c[k] = c[k-1] ^ fmul(c[k], b);
        c[0] = fmul(c[0], b);
        deg++;
      end
    for (int k = 0; k <= 50; k++) begin
      g_ref[k] = c[k][0];
      if ((c[k] >> 1) != 0) chk(0, "R3", "generator coefficient not binary", 64'(c[k]), 64'(c[k] & 1));
    end
    chk(g_ref[50] && g_ref[0], "R3", "generator end terms", 64'(g_ref[50]), 64'd1);
  endtask

  function automatic logic [49:0] ref_par(input logic [299:0] info);
    logic [49:0] r;
    logic fb;
    r = '0;
    for (int i = 299; i >= 0; i--) begin
      fb = info[i] ^ r[49];
      r = {r[48:0], 1'b0} ^ (fb ? g_ref[49:0] : 50'd0);
    end
    return r;
  endfunction

  function automatic logic [49:0] cw_mod(input logic [349:0] cw);
    logic [49:0] r;
    logic fb;
    r = '0;
    for (int i = 349; i >= 0; i--) begin
      fb = r[49];
      r = {r[48:0], cw[i]} ^ (fb ? g_ref[49:0] : 50'd0);
    end
    return r;
  endfunction

  task automatic run_cw(input logic [299:0] info, input int gap_pct, input bit garb);
    logic [349:0] cw;
    logic [49:0]  ep;
    logic [9:0]   w;
    cw = '0;
    ep = ref_par(info);
    for (int i = 0; i < 30; i++) begin
      if (int'($urandom % 100) < gap_pct) begin
        int ng;
        ng = 1 + int'($urandom % 3);
        for (int q = 0; q < ng; q++) begin
          in_valid = 1'b0; in_start = 1'($urandom); in_data = 10'($urandom);
          step();
          chk(!out_valid, "R6", "output during pause", 64'(out_valid), 64'd0);
        end
      end
      w = info[299 - 10*i -: 10];
      in_valid = 1'b1; in_start = (i == 0); in_data = w;
      step();
      chk(out_valid && !out_parity && out_data == w, "R1 R2", "info word passthrough",
          {out_valid, out_parity, 52'd0, out_data}, {1'b1, 1'b0, 52'd0, w});
      cw[349 - 10*i -: 10] = out_data;
    end
    in_valid = 1'b0; in_start = 1'b0;
    chk(!in_ready, "R5", "ready after last info word", 64'(in_ready), 64'd0);
    for (int p = 0; p < 5; p++) begin
      in_valid = garb; in_start = 1'($urandom); in_data = 10'($urandom);
      step();
      chk(out_valid && out_parity && out_data == ep[49 - 10*p -: 10], "R3", "parity word",
          64'(out_data), 64'(ep[49 - 10*p -: 10]));
      chk(out_last == (p == 4), "R4", "last flag", 64'(out_last), 64'(p == 4));
      chk(in_ready == (p == 4), "R5", "ready during drain", 64'(in_ready), 64'(p == 4));
      cw[49 - 10*p -: 10] = out_data;
    end
    in_valid = 1'b0; in_start = 1'b0;
    chk(cw_mod(cw) == '0, "R3", "codeword divisible by g", 64'(cw_mod(cw)), 64'd0);
    step();
    chk(!out_valid, "R5", "no output from words offered in drain", 64'(out_valid), 64'd0);
  endtask

  function automatic logic [299:0] rand_info();
    logic [299:0] v;
    for (int i = 0; i < 10; i++) v[30*i +: 30] = 30'($urandom);
    return v;
  endfunction

  initial begin
    void'($urandom(32'd2024));
    build_gen();
    repeat (3) step();
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid && in_ready, "R9", "reset state", {62'd0, out_valid, in_ready}, 64'd1);

    run_cw('0, 0, 1'b0);
    run_cw({300{1'b1}}, 0, 1'b1);
    run_cw({1'b1, 299'd0}, 0, 1'b0);
    run_cw(300'd1, 0, 1'b1);

    // R8: stray words with no codeword open
    for (int i = 0; i < 4; i++) begin
      in_valid = 1'b1; in_start = 1'b0; in_data = 10'($urandom);
      step();
      chk(!out_valid, "R8", "stray word produced output", 64'(out_valid), 64'd0);
    end
    in_valid = 1'b0;
    run_cw(rand_info(), 0, 1'b0);

    // R7: abandon a partial codeword with a new start
    for (int i = 0; i < 12; i++) begin
      logic [9:0] w;
      w = 10'($urandom);
      in_valid = 1'b1; in_start = (i == 0); in_data = w;
      step();
      chk(out_valid && out_data == w, "R7", "partial word passthrough", 64'(out_data), 64'(w));
    end
    run_cw(rand_info(), 0, 1'b1);

    for (int n = 0; n < 20; n++) run_cw(rand_info(), 30, 1'($urandom));

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule